// File: doc/BRIEF.md
# Address Error Exception Entry Sequencer

This block performs the processor-side entry into an address-error exception. A bus checker raises a one-cycle error pulse together with an error-type code. The sequencer kills the faulting bus cycle at once, then holds off until the instruction in flight reports completion. Only then does it take a snapshot of the status word, the address of the next instruction, the stack pointer and the vector base.

With that snapshot it drives a single-outstanding memory port through three handshaked transfers. The first pushes the status word onto a downward-growing stack. The second pushes the resume address. The third reads the handler address from the vector table slot that the error type selects. It then issues a one-cycle redirect strobe with the handler address and the updated stack pointer. The redirect is a plain jump: fetch continues at the handler with no delay-slot instruction in between.

Top module: `aerr_entry_seq`

## Requirements
- R1: `bus_abort` is high in every cycle in which `err_pulse` is high, whatever the sequencer state, with no register in between.
- R2: While idle, `err_pulse` starts a sequence and latches `err_kind`. `busy` is high from the next cycle through the cycle of `pc_load` inclusive, and is low otherwise.
- R3: No memory request is made until `insn_done` is seen high in a cycle after the error was latched. `sr_in`, `next_pc`, `sp_in` and `vbr_in` are sampled at that clock edge, and later changes on them have no effect.
- R4: The first request is a write (`mem_we`=1) to address `sp_in`-4 with data `sr_in`.
- R5: The second request is a write (`mem_we`=1) to address `sp_in`-8 with data `next_pc`.
- R6: The third request is a read (`mem_we`=0) at `vbr_in` + 4*(`VEC_FIRST` + `err_kind`), where `VEC_FIRST` defaults to 8 and `err_kind` is an unsigned 2-bit code.
- R7: Each request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high. The next request, if any, appears in the following cycle.
- R8: In the cycle after the read is acknowledged, `pc_load` pulses for exactly one cycle with `pc_out` equal to the `mem_rdata` seen at that acknowledge. `pc_out` keeps that value afterwards, and `pc_load` never pulses at any other time.
- R9: While `pc_load` is high, `sp_out` equals the sampled `sp_in` minus 8.
- R10: An `err_pulse` that arrives while `busy` is high, including the `pc_load` cycle, does not change the latched error type and does not start a further sequence.
- R11: After reset, `busy`, `mem_req` and `pc_load` are low, and `pc_out` and `sp_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | 1 | Address error detected by the bus checker |
| err_kind | input | 2 | Error type, selects the vector slot |
| insn_done | input | 1 | The executing instruction has completed |
| sr_in | input | 32 | Current status word |
| next_pc | input | 32 | Start address of the next instruction |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base address |
| bus_abort | output | 1 | Terminate the current bus cycle |
| busy | output | 1 | Exception entry in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory transfer accepted or completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| pc_out | output | 32 | Handler address |
| pc_load | output | 1 | Redirect fetch to pc_out |
| sp_out | output | 32 | Stack pointer after the two pushes |

## Verification
The abort output follows the error input within the same cycle, so it is sampled at the falling edge of that cycle. `busy` rises one edge after the error, and each memory request appears one edge after the `insn_done` or `mem_ack` that enables it. The bench therefore drives every input at a falling edge and checks the outputs at the next falling edge. It repeats that check on each idle or stalled cycle. The redirect strobe is due one edge after the vector read is acknowledged and `busy` drops one edge later. The bench samples both at those exact falling edges, so an early, late or stretched pulse shows up as a mismatch.

// File: rtl/aerr_pkg.sv
package aerr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_PSR  = 3'd2,
    ST_PPC  = 3'd3,
    ST_FVEC = 3'd4,
    ST_JUMP = 3'd5
  } seq_st_t;
endpackage

// File: rtl/aerr_fsm.sv
module aerr_fsm
  import aerr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    err_pulse,
  input  logic    insn_done,
  input  logic    mem_ack,
  output seq_st_t state_q,
  output logic    take_err,
  output logic    take_ctx,
  output logic    push_done,
  output logic    vec_done
);
  seq_st_t state_d;

  always_comb begin
    state_d   = state_q;
    take_err  = 1'b0;
    take_ctx  = 1'b0;
    push_done = 1'b0;
    vec_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (err_pulse) begin
        take_err = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: if (insn_done) begin
        take_ctx = 1'b1;
        state_d  = ST_PSR;
      end
      ST_PSR: if (mem_ack) begin
        push_done = 1'b1;
        state_d   = ST_PPC;
      end
      ST_PPC: if (mem_ack) begin
        push_done = 1'b1;
        state_d   = ST_FVEC;
      end
      ST_FVEC: if (mem_ack) begin
        vec_done = 1'b1;
        state_d  = ST_JUMP;
      end
      ST_JUMP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/aerr_sp_unit.sv
module aerr_sp_unit #(
  parameter int XLEN = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [XLEN-1:0] load_val,
  input  logic            dec_en,
  output logic [XLEN-1:0] sp_q,
  output logic [XLEN-1:0] push_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(SLOT_BYTES);
  logic [XLEN-1:0] sp_d;

  assign push_addr = sp_q - STEP;

  always_comb begin
    sp_d = sp_q;
    if (load_en)     sp_d = load_val;
    else if (dec_en) sp_d = push_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (load_en || dec_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/aerr_vec_calc.sv
module aerr_vec_calc #(
  parameter int XLEN = 32,
  parameter int KIND_W = 2,
  parameter int VEC_FIRST = 8
) (
  input  logic [XLEN-1:0]   base,
  input  logic [KIND_W-1:0] kind,
  output logic [XLEN-1:0]   vec_addr
);
  localparam logic [XLEN-1:0] FIRST = XLEN'(VEC_FIRST);
  logic [XLEN-1:0] vec_num;

  assign vec_num  = FIRST + XLEN'(kind);
  assign vec_addr = base + (vec_num << 2);
endmodule

// File: rtl/aerr_entry_seq.sv
module aerr_entry_seq
  import aerr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int KIND_W = 2,
  parameter int VEC_FIRST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_pulse,
  input  logic [KIND_W-1:0] err_kind,
  input  logic              insn_done,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   next_pc,
  input  logic [XLEN-1:0]   sp_in,
  input  logic [XLEN-1:0]   vbr_in,
  output logic              bus_abort,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   pc_out,
  output logic              pc_load,
  output logic [XLEN-1:0]   sp_out
);
  seq_st_t           state_q;
  logic              take_err, take_ctx, push_done, vec_done;
  logic [KIND_W-1:0] kind_q;
  logic [XLEN-1:0]   sr_q, pc_q, vbr_q, hnd_q;
  logic [XLEN-1:0]   push_addr, vec_addr;

  aerr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse (err_pulse),
    .insn_done (insn_done),
    .mem_ack   (mem_ack),
    .state_q   (state_q),
    .take_err  (take_err),
    .take_ctx  (take_ctx),
    .push_done (push_done),
    .vec_done  (vec_done)
  );

  aerr_sp_unit #(.XLEN(XLEN), .SLOT_BYTES(4)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (take_ctx),
    .load_val  (sp_in),
    .dec_en    (push_done),
    .sp_q      (sp_out),
    .push_addr (push_addr)
  );

  aerr_vec_calc #(.XLEN(XLEN), .KIND_W(KIND_W), .VEC_FIRST(VEC_FIRST)) u_vec (
    .base     (vbr_q),
    .kind     (kind_q),
    .vec_addr (vec_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= '0;
    else if (take_err) kind_q <= err_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      pc_q  <= '0;
      vbr_q <= '0;
    end else if (take_ctx) begin
      sr_q  <= sr_in;
      pc_q  <= next_pc;
      vbr_q <= vbr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hnd_q <= '0;
    else if (vec_done) hnd_q <= mem_rdata;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PSR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = sr_q;
      end
      ST_PPC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = pc_q;
      end
      ST_FVEC: begin
        mem_req   = 1'b1;
        mem_addr  = vec_addr;
      end
      default: ;
    endcase
  end

  assign bus_abort = err_pulse;
  assign busy      = (state_q != ST_IDLE);
  assign pc_load   = (state_q == ST_JUMP);
  assign pc_out    = hnd_q;
endmodule

// File: rtl/aerr_entry_seq_chk.sv
module aerr_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            err_pulse,
  input logic            bus_abort,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            pc_load
);
  // R1
  abort_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> bus_abort);

  // R2
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !pc_load);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load && !busy);

  // R2
  busy_ends_on_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_load));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && err_pulse) |=> !busy);
endmodule

bind aerr_entry_seq aerr_entry_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_pulse (err_pulse),
  .bus_abort (bus_abort),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc_load   (pc_load)
);

// File: tb/aerr_entry_seq_tb.sv
module aerr_entry_seq_tb_top;
  localparam int VEC_FIRST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_pulse = 1'b0;
  logic [1:0]  err_kind = '0;
  logic        insn_done = 1'b0;
  logic [31:0] sr_in = '0, next_pc = '0, sp_in = '0, vbr_in = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        bus_abort, busy, mem_req, mem_we, pc_load;
  logic [31:0] mem_addr, mem_wdata, pc_out, sp_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  aerr_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_kind(err_kind),
    .insn_done(insn_done), .sr_in(sr_in), .next_pc(next_pc), .sp_in(sp_in),
    .vbr_in(vbr_in), .bus_abort(bus_abort), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .pc_load(pc_load), .sp_out(sp_out)
  );

  function automatic logic [31:0] exp_vec(input logic [31:0] b, input logic [1:0] k);
    return b + 32'((VEC_FIRST + int'(k)) * 4);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_req(input string tag, input logic we, input logic [31:0] a, input logic [31:0] d);
    chk(mem_req === 1'b1, {tag, " req"}, 32'(mem_req), 32'd1);
    chk(mem_we === we, {tag, " we"}, 32'(mem_we), 32'(we));
    chk(mem_addr === a, {tag, " addr"}, mem_addr, a);
    if (we) chk(mem_wdata === d, {tag, " data"}, mem_wdata, d);
  endtask

  task automatic run_seq(input logic [1:0] kind, input logic [31:0] sr, input logic [31:0] pc,
                         input logic [31:0] sp, input logic [31:0] vb, input logic [31:0] hnd,
                         input int wc, input int d0, input int d1, input int d2,
                         input logic dup_err, input logic late_err);
    err_pulse = 1'b1; err_kind = kind;
    #1 chk(bus_abort === 1'b1, "R1 abort", 32'(bus_abort), 32'd1);
    step();
    err_pulse = dup_err; err_kind = ~kind;
    #1 chk(busy === 1'b1, "R2 busy rise", 32'(busy), 32'd1);
    if (dup_err) chk(bus_abort === 1'b1, "R1 abort while busy", 32'(bus_abort), 32'd1);
    sr_in = sr; next_pc = pc; sp_in = sp; vbr_in = vb;
    for (int i = 0; i < wc; i++) begin
      step();
      err_pulse = 1'b0;
      chk(mem_req === 1'b0, "R3 no req before done", 32'(mem_req), 32'd0);
    end
    err_pulse = 1'b0;
    insn_done = 1'b1;
    step();
    insn_done = 1'b0;
    sr_in = ~sr; next_pc = ~pc; sp_in = ~sp; vbr_in = ~vb;
    chk_req("R4 push sr", 1'b1, sp - 32'd4, sr);
    for (int i = 0; i < d0; i++) begin step(); chk_req("R7 hold sr", 1'b1, sp - 32'd4, sr); end
    mem_ack = 1'b1; step(); mem_ack = 1'b0;
    chk_req("R5 push pc", 1'b1, sp - 32'd8, pc);
    for (int i = 0; i < d1; i++) begin step(); chk_req("R7 hold pc", 1'b1, sp - 32'd8, pc); end
    mem_ack = 1'b1; step(); mem_ack = 1'b0;
    chk_req("R6 vec read", 1'b0, exp_vec(vb, kind), 32'd0);
    for (int i = 0; i < d2; i++) begin step(); chk_req("R7 hold vec", 1'b0, exp_vec(vb, kind), 32'd0); end
    mem_ack = 1'b1; mem_rdata = hnd; step(); mem_ack = 1'b0; mem_rdata = 32'hdead_0000;
    chk(pc_load === 1'b1, "R8 pc_load", 32'(pc_load), 32'd1);
    chk(pc_out === hnd, "R8 pc_out", pc_out, hnd);
    chk(sp_out === sp - 32'd8, "R9 sp_out", sp_out, sp - 32'd8);
    chk(busy === 1'b1, "R2 busy at jump", 32'(busy), 32'd1);
    chk(mem_req === 1'b0, "R8 no req at jump", 32'(mem_req), 32'd0);
    err_pulse = late_err;
    step();
    err_pulse = 1'b0;
    chk(pc_load === 1'b0, "R8 single pulse", 32'(pc_load), 32'd0);
    chk(busy === 1'b0, "R2 busy fall", 32'(busy), 32'd0);
    chk(pc_out === hnd, "R8 pc_out held", pc_out, hnd);
    step();
    chk(busy === 1'b0 && mem_req === 1'b0, "R10 no restart", 32'(busy), 32'd0);
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R11 busy", 32'(busy), 32'd0);
    chk(mem_req === 1'b0, "R11 mem_req", 32'(mem_req), 32'd0);
    chk(pc_load === 1'b0, "R11 pc_load", 32'(pc_load), 32'd0);
    chk(pc_out === 32'd0, "R11 pc_out", pc_out, 32'd0);
    chk(sp_out === 32'd0, "R11 sp_out", sp_out, 32'd0);
    rst_n = 1'b1;
    step();
    insn_done = 1'b1; step(); insn_done = 1'b0; step();
    chk(busy === 1'b0 && mem_req === 1'b0, "R3 done while idle ignored", 32'(busy), 32'd0);
    // directed corners: zero delays, highest kind, stack wrap, repeated errors
    run_seq(2'd0, 32'h0000_00f0, 32'h0000_1002, 32'hffff_f000, 32'h0000_0000, 32'h0000_4000, 0, 0, 0, 0, 1'b0, 1'b0);
    run_seq(2'd3, 32'h8000_0001, 32'h1234_5678, 32'h0000_0004, 32'hffff_ff00, 32'hcafe_0010, 3, 2, 1, 3, 1'b1, 1'b1);
    run_seq(2'd1, 32'h5555_aaaa, 32'h0000_0000, 32'h0000_0000, 32'h0100_0000, 32'h0000_0002, 1, 1, 0, 0, 1'b1, 1'b0);
    for (int n = 0; n < 25; n++) begin
      run_seq(2'($urandom_range(3)), $urandom, $urandom & 32'hffff_fffe, $urandom & 32'hffff_fffc,
              $urandom & 32'hffff_fc00, $urandom, int'($urandom_range(4)), int'($urandom_range(3)),
              int'($urandom_range(3)), int'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule